// File: doc/BRIEF.md
# Segment-Test Corner Detector

This block judges one candidate pixel per clock. It receives the intensity of the candidate, the sixteen intensities that lie on a radius-3 ring around it, and a valid strobe. Two comparator arrays classify every ring pixel against a threshold band around the centre, one array producing a brighter mask and the other a darker mask. The candidate is a corner when either mask alone holds a contiguous arc of at least twelve set positions, with the arc free to wrap from the last ring position back to the first.

A cheap pre-test looks only at the four compass positions of the ring and flags the candidate as rejected when fewer than three of them agree on the same side. For each corner the block also reports a contrast score, which is the summed absolute difference between the centre and the pixels of the qualifying arc's mask, so that a later suppression stage can keep the strongest of neighbouring detections. The threshold is held in a register that software-independent logic upstream loads with a write strobe, and it comes out of reset at 10. The datapath is a two-stage pipeline that accepts a new candidate every cycle.

Top module: `seg_corner_det`

## Requirements
- R1: A ring pixel is brighter when its value is at least centre plus threshold, the sum clamped to 255; so with centre 250 and threshold 10, a ring value of 255 is brighter.
- R2: A ring pixel is darker when its value is at most centre minus threshold, the difference clamped to 0; so with centre 5 and threshold 10, a ring value of 0 is darker.
- R3: is_corner is 1 when the brighter mask or the darker mask has 12 or more consecutive set positions, where position 16 is adjacent to position 1 (ring position k occupies bits [8k-1:8k-8] of the ring bus).
- R4: A run made partly of brighter and partly of darker pixels does not qualify; each mask is tested on its own.
- R5: rejected is 1 when fewer than three of ring positions 1, 5, 9 and 13 are brighter and fewer than three of them are darker; a rejected candidate never has is_corner set.
- R6: score is the sum of |ring - centre| over the set positions of the qualifying mask (the brighter mask when both qualify) and is 0 when is_corner is 0.
- R7: The threshold register holds 10 after reset, loads thr_in on a cycle where thr_wr is 1, and a candidate presented in that same cycle still uses the previous value.
- R8: out_valid rises exactly two cycles after in_valid, back-to-back candidates are each reported in order, and is_corner, rejected and score are 0 whenever out_valid is 0.
- R9: A run of exactly 11 set positions is not a corner, even when it passes the pre-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_in | input | 8 | New threshold value |
| in_valid | input | 1 | Candidate present this cycle |
| center | input | 8 | Intensity of the candidate pixel |
| ring | input | 128 | Sixteen ring intensities, position 1 in the low byte |
| out_valid | output | 1 | Result present this cycle |
| is_corner | output | 1 | Candidate is a corner |
| rejected | output | 1 | Candidate failed the compass pre-test |
| score | output | 12 | Contrast score of a corner |

## Verification
The hardest situations to reach from the ports are those where the two classification paths disagree with each other or with the pre-test: an eleven-long arc that still passes the compass check, a full-length ring whose two halves fall into different masks, and an arc that only reaches twelve by wrapping past position 16. The stimulus builds each ring from a brighter mask, a darker mask and an offset, so these shapes are written as explicit bit patterns; clamped comparisons are reached by choosing centres near 0 and 255, and a threshold of zero makes every pixel fall in both masks at once to expose the priority of the score.

// File: rtl/segc_pkg.sv
package segc_pkg;
  parameter int PIX_W       = 8;
  parameter int RING_N      = 16;
  parameter int ARC_MIN     = 12;
  parameter int CARD_MIN    = 3;
  parameter int THR_DEFAULT = 10;
  localparam int SCORE_W    = PIX_W + $clog2(RING_N);
endpackage

// File: rtl/segc_compare.sv
module segc_compare #(
  parameter int PIX_W  = 8,
  parameter int RING_N = 16
) (
  input  logic [PIX_W-1:0]        center,
  input  logic [PIX_W-1:0]        thr,
  input  logic [RING_N*PIX_W-1:0] ring,
  output logic [RING_N-1:0]       bright,
  output logic [RING_N-1:0]       dark,
  output logic [RING_N*PIX_W-1:0] adiff
);
  logic [PIX_W:0]   hi_sum;
  logic [PIX_W-1:0] hi_lim;
  logic [PIX_W-1:0] lo_lim;

  // clamped band limits around the centre
  always_comb begin
    hi_sum = {1'b0, center} + {1'b0, thr};
    hi_lim = hi_sum[PIX_W] ? {PIX_W{1'b1}} : hi_sum[PIX_W-1:0];
    lo_lim = (thr > center) ? '0 : center - thr;
  end

  for (genvar k = 0; k < RING_N; k++) begin : g_cmp
    logic [PIX_W-1:0] px;
    assign px                   = ring[k*PIX_W +: PIX_W];
    assign bright[k]            = (px >= hi_lim);
    assign dark[k]              = (px <= lo_lim);
    assign adiff[k*PIX_W +: PIX_W] = (px >= center) ? px - center : center - px;
  end
endmodule

// File: rtl/segc_arc.sv
module segc_arc #(
  parameter int RING_N  = 16,
  parameter int ARC_MIN = 12
) (
  input  logic [RING_N-1:0] mask,
  output logic              hit
);
  logic [RING_N-1:0] start_ok;

  // one window per starting position, wrapping around the ring
  for (genvar s = 0; s < RING_N; s++) begin : g_start
    always_comb begin
      start_ok[s] = 1'b1;
      for (int k = 0; k < ARC_MIN; k++) begin
        start_ok[s] = start_ok[s] & mask[(s + k) % RING_N];
      end
    end
  end

  assign hit = |start_ok;
endmodule

// File: rtl/segc_score.sv
module segc_score #(
  parameter int PIX_W   = 8,
  parameter int RING_N  = 16,
  parameter int SCORE_W = 12
) (
  input  logic [RING_N-1:0]       sel,
  input  logic [RING_N*PIX_W-1:0] adiff,
  output logic [SCORE_W-1:0]      sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < RING_N; k++) begin
      if (sel[k]) sum = sum + SCORE_W'(adiff[k*PIX_W +: PIX_W]);
    end
  end
endmodule

// File: rtl/seg_corner_det.sv
module seg_corner_det
  import segc_pkg::*;
#(
  parameter int P_PIX_W    = PIX_W,
  parameter int P_RING_N   = RING_N,
  parameter int P_ARC_MIN  = ARC_MIN,
  parameter int P_CARD_MIN = CARD_MIN,
  parameter int P_THR_DEF  = THR_DEFAULT,
  localparam int SC_W      = P_PIX_W + $clog2(P_RING_N),
  localparam int CARD_STEP = P_RING_N / 4,
  localparam int CNT_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        thr_wr,
  input  logic [P_PIX_W-1:0]          thr_in,
  input  logic                        in_valid,
  input  logic [P_PIX_W-1:0]          center,
  input  logic [P_RING_N*P_PIX_W-1:0] ring,
  output logic                        out_valid,
  output logic                        is_corner,
  output logic                        rejected,
  output logic [SC_W-1:0]             score
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // threshold register
  logic [P_PIX_W-1:0] thr_q, thr_d;
  always_comb thr_d = thr_wr ? thr_in : thr_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) thr_q <= P_PIX_W'(P_THR_DEF);
    else             thr_q <= thr_d;
  end

  // stage 1: comparator arrays
  logic [P_RING_N-1:0]         c_bright, c_dark;
  logic [P_RING_N*P_PIX_W-1:0] c_adiff;

  segc_compare #(.PIX_W(P_PIX_W), .RING_N(P_RING_N)) u_cmp (
    .center(center), .thr(thr_q), .ring(ring),
    .bright(c_bright), .dark(c_dark), .adiff(c_adiff)
  );

  logic                        s1_valid, s1_valid_d;
  logic [P_RING_N-1:0]         s1_bright, s1_dark, s1_bright_d, s1_dark_d;
  logic [P_RING_N*P_PIX_W-1:0] s1_adiff, s1_adiff_d;

  always_comb begin
    s1_valid_d  = in_valid;
    s1_bright_d = s1_bright;
    s1_dark_d   = s1_dark;
    s1_adiff_d  = s1_adiff;
    if (in_valid) begin
      s1_bright_d = c_bright;
      s1_dark_d   = c_dark;
      s1_adiff_d  = c_adiff;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid  <= 1'b0;
      s1_bright <= '0;
      s1_dark   <= '0;
      s1_adiff  <= '0;
    end else begin
      s1_valid  <= s1_valid_d;
      s1_bright <= s1_bright_d;
      s1_dark   <= s1_dark_d;
      s1_adiff  <= s1_adiff_d;
    end
  end

  // stage 2: arc search, compass pre-test, score
  logic b_hit, d_hit;
  segc_arc #(.RING_N(P_RING_N), .ARC_MIN(P_ARC_MIN)) u_arc_b (.mask(s1_bright), .hit(b_hit));
  segc_arc #(.RING_N(P_RING_N), .ARC_MIN(P_ARC_MIN)) u_arc_d (.mask(s1_dark),   .hit(d_hit));

  logic [CNT_W-1:0] card_b, card_d;
  logic             pre_rej;
  always_comb begin
    card_b = '0;
    card_d = '0;
    for (int q = 0; q < 4; q++) begin
      card_b = card_b + CNT_W'(s1_bright[q*CARD_STEP]);
      card_d = card_d + CNT_W'(s1_dark[q*CARD_STEP]);
    end
    pre_rej = (card_b < CNT_W'(P_CARD_MIN)) && (card_d < CNT_W'(P_CARD_MIN));
  end

  logic [P_RING_N-1:0] sel_mask;
  logic [SC_W-1:0]     sad;
  always_comb sel_mask = b_hit ? s1_bright : (d_hit ? s1_dark : '0);

  segc_score #(.PIX_W(P_PIX_W), .RING_N(P_RING_N), .SCORE_W(SC_W)) u_sad (
    .sel(sel_mask), .adiff(s1_adiff), .sum(sad)
  );

  logic            ov_d, corner_d, rej_d;
  logic [SC_W-1:0] score_d;
  always_comb begin
    ov_d     = s1_valid;
    corner_d = 1'b0;
    rej_d    = 1'b0;
    score_d  = '0;
    if (s1_valid) begin
      rej_d    = pre_rej;
      corner_d = !pre_rej && (b_hit || d_hit);
      score_d  = corner_d ? sad : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      is_corner <= 1'b0;
      rejected  <= 1'b0;
      score     <= '0;
    end else begin
      out_valid <= ov_d;
      is_corner <= corner_d;
      rejected  <= rej_d;
      score     <= score_d;
    end
  end
endmodule

// File: rtl/segc_chk.sv
module segc_chk #(
  parameter int PIX_W = 8,
  parameter int SC_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_wr,
  input logic [PIX_W-1:0] thr_in,
  input logic [PIX_W-1:0] thr_q,
  input logic             in_valid,
  input logic             out_valid,
  input logic             is_corner,
  input logic             rejected,
  input logic [SC_W-1:0]  score
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!is_corner && !rejected && score == '0));

  // R5
  rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !is_corner);

  // R6
  score_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_corner) |-> (score == '0));

  // R7
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_in)));
endmodule

bind seg_corner_det segc_chk #(.PIX_W(P_PIX_W), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .thr_wr(thr_wr), .thr_in(thr_in),
  .thr_q(thr_q), .in_valid(in_valid), .out_valid(out_valid),
  .is_corner(is_corner), .rejected(rejected), .score(score)
);

// File: tb/seg_corner_det_test.sv
module seg_corner_det_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         thr_wr;
  logic [7:0]   thr_in;
  logic         in_valid;
  logic [7:0]   center;
  logic [127:0] ring;
  logic         out_valid, is_corner, rejected;
  logic [11:0]  score;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5ns clk = ~clk;

  seg_corner_det uut (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_in(thr_in),
    .in_valid(in_valid), .center(center), .ring(ring),
    .out_valid(out_valid), .is_corner(is_corner), .rejected(rejected), .score(score)
  );

  // {center, thr, bright mask, dark mask, offset, exp corner, exp rejected, exp score}
  localparam int NV = 14;
  localparam logic [69:0] VEC [NV] = '{
    {8'd100, 8'd10, 16'hFFFF, 16'h0000, 8'd20, 1'b1, 1'b0, 12'd320}, // R3 full bright ring
    {8'd100, 8'd10, 16'h0FFF, 16'h0000, 8'd20, 1'b1, 1'b0, 12'd240}, // R3 run of 12
    {8'd100, 8'd10, 16'h07FF, 16'h0000, 8'd20, 1'b0, 1'b0, 12'd0},   // R9 run of 11
    {8'd100, 8'd10, 16'hFC3F, 16'h0000, 8'd20, 1'b1, 1'b0, 12'd240}, // R3 wrapping bright arc
    {8'd100, 8'd10, 16'h0000, 16'hFFF0, 8'd20, 1'b1, 1'b0, 12'd240}, // R3 dark arc
    {8'd100, 8'd10, 16'h07FF, 16'hF800, 8'd20, 1'b0, 1'b0, 12'd0},   // R4 mixed ring
    {8'd100, 8'd10, 16'h0011, 16'h0000, 8'd20, 1'b0, 1'b1, 12'd0},   // R5 two compass hits
    {8'd100, 8'd10, 16'hFFFF, 16'h0000, 8'd10, 1'b1, 1'b0, 12'd160}, // R1 exactly at band
    {8'd100, 8'd11, 16'hFFFF, 16'h0000, 8'd10, 1'b0, 1'b1, 12'd0},   // R1 one short of band
    {8'd250, 8'd10, 16'hFFFF, 16'h0000, 8'd5,  1'b1, 1'b0, 12'd80},  // R1 clamp at 255
    {8'd5,   8'd10, 16'h0000, 16'hFFFF, 8'd5,  1'b1, 1'b0, 12'd80},  // R2 clamp at 0
    {8'd100, 8'd0,  16'h0000, 16'h0000, 8'd0,  1'b1, 1'b0, 12'd0},   // R6 both masks, bright wins
    {8'd100, 8'd10, 16'h0000, 16'hF0FF, 8'd20, 1'b1, 1'b0, 12'd240}, // R2 wrapping dark arc
    {8'd100, 8'd10, 16'h0FFF, 16'hF000, 8'd20, 1'b1, 1'b0, 12'd240}  // R6 other mask excluded
  };

  function automatic logic [127:0] mk_ring(logic [7:0] c, logic [15:0] bm, logic [15:0] dm,
                                           logic [7:0] off);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) begin
      if (bm[k])      r[k*8 +: 8] = c + off;
      else if (dm[k]) r[k*8 +: 8] = c - off;
      else            r[k*8 +: 8] = c;
    end
    return r;
  endfunction

  task automatic check(string tag, logic ev, logic ec, logic er, logic [11:0] es);
    n_chk++;
    if (out_valid !== ev || is_corner !== ec || rejected !== er || score !== es) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b corner=%0b rej=%0b score=%0d, expected valid=%0b corner=%0b rej=%0b score=%0d",
               tag, out_valid, is_corner, rejected, score, ev, ec, er, es);
    end
  endtask

  task automatic drive(logic [7:0] c, logic [15:0] bm, logic [15:0] dm, logic [7:0] off);
    in_valid = 1'b1;
    center   = c;
    ring     = mk_ring(c, bm, dm, off);
  endtask

  task automatic write_thr(logic [7:0] t);
    thr_wr = 1'b1;
    thr_in = t;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic one(string tag, logic [7:0] c, logic [15:0] bm, logic [15:0] dm,
                     logic [7:0] off, logic ec, logic er, logic [11:0] es);
    drive(c, bm, dm, off);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(tag, 1'b1, ec, er, es);
  endtask

  initial begin
    rst_n = 1'b0; thr_wr = 1'b0; thr_in = '0; in_valid = 1'b0; center = '0; ring = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", 1'b0, 1'b0, 1'b0, 12'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: default threshold of 10 without any write
    one("R7 default thr, offset 10", 8'd100, 16'hFFFF, 16'h0000, 8'd10, 1'b1, 1'b0, 12'd160);
    one("R7 default thr, offset 9",  8'd100, 16'hFFFF, 16'h0000, 8'd9,  1'b0, 1'b1, 12'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      write_thr(v[61:54]);
      one($sformatf("vector %0d (R1-R6/R9 table)", i), v[69:62], v[53:38], v[37:22],
          v[21:14], v[13], v[12], v[11:0]);
    end

    // R8: back-to-back candidates, exact latency
    write_thr(8'd10);
    drive(8'd100, 16'hFFFF, 16'h0000, 8'd20);
    @(negedge clk);
    check("R8 no result after one edge", 1'b0, 1'b0, 1'b0, 12'd0);
    drive(8'd100, 16'h07FF, 16'h0000, 8'd20);
    @(negedge clk);
    check("R8 stream first", 1'b1, 1'b1, 1'b0, 12'd320);
    drive(8'd100, 16'h0011, 16'h0000, 8'd20);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 stream second", 1'b1, 1'b0, 1'b0, 12'd0);
    @(negedge clk);
    check("R8 stream third", 1'b1, 1'b0, 1'b1, 12'd0);
    @(negedge clk);
    check("R8 idle after stream", 1'b0, 1'b0, 1'b0, 12'd0);

    // R7: write in the same cycle as a candidate uses the old threshold
    thr_wr = 1'b1;
    thr_in = 8'd11;
    drive(8'd100, 16'hFFFF, 16'h0000, 8'd10);
    @(negedge clk);
    thr_wr = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 same-cycle write uses old thr", 1'b1, 1'b1, 1'b0, 12'd160);
    one("R7 new thr applies next", 8'd100, 16'hFFFF, 16'h0000, 8'd10, 1'b0, 1'b1, 12'd0);

    // R8: reset clears results mid-run
    drive(8'd100, 16'hFFFF, 16'h0000, 8'd20);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears output", 1'b0, 1'b0, 1'b0, 12'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    one("R7 thr back to 10 after reset", 8'd100, 16'hFFFF, 16'h0000, 8'd10, 1'b1, 1'b0, 12'd160);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule